// File: doc/BRIEF.md
# Program/Erase Status Reporter

This block builds the word a host sees when it reads a flash device while an embedded program or erase runs or has just ended. An operation engine tells it when an operation starts (with its kind and the last loaded data), when it finishes, and when it fails. Failure covers two cases: the internal pulse-count limit was exceeded, or the target sector was locked. From these indications the block drives a polling bit, a toggle bit, a failure bit and an open-drain ready/busy pull-down. It also decides whether the device goes back to array reads by itself or stays in status mode until an exit command arrives.

A two-bit configuration value selects what the polling bit means. It also selects whether a successful operation returns to array reads without help. This value is cleared only by power-on reset. A pulse on the reset pin leaves it alone. In array mode a read returns the array data unchanged. In status mode every bit that is not a status bit reads 0.

Top module: `flash_status_unit`

## Requirements
- R1: The configuration value is 00 after power-on reset, and a pin reset leaves it unchanged. A configuration write is taken only in array mode and stores {0, data bit 0}, so data bit 1 is dropped.
- R2: With configuration 00, an active operation puts on bit 7 the inverse of bit 7 of the loaded data for a program and 0 for an erase. A failed operation keeps showing the same value.
- R3: With configuration 01, bit 7 reads 0 while an operation is active. It reads 1 once the operation has finished, whether it succeeded or failed.
- R4: Bit 6 comes from a flag that is cleared by any reset. Each read in the running or failed state returns the flag and then inverts it. Reads in the finished-success state return the flag without changing it.
- R5: Bit 5 reads 0 while an operation runs and 1 after a failure.
- R6: After a failure the block stays in status mode until an exit command. After the exit, reads return array data.
- R7: After a success, configuration 00 returns to array mode on its own. Configuration 01 stays in status mode until an exit command.
- R8: `rdy_low_o` goes to 1 in the cycle after a start is accepted. It goes back to 0 in the cycle after a done or fail pulse.
- R9: Read data is registered: one cycle after a read strobe, `rd_data_o` shows the array word in array mode, or the status word in status mode with every bit other than 7, 6 and 5 at 0.
- R10: After a pin reset or a power-on reset, `rd_data_o` is 0, `rdy_low_o` is 0 and the block is in array mode.
- R11: While an operation runs, exit commands, configuration writes and new starts have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; also clears the configuration value |
| rst | input | 1 | Reset pin, synchronous, active high; leaves the configuration value alone |
| start_i | input | 1 | One-cycle pulse: an operation begins (taken in array mode only) |
| erase_i | input | 1 | Operation kind with start_i: 1 erase, 0 program |
| load_data_i | input | DATA_W | Last loaded data, captured with start_i |
| done_i | input | 1 | One-cycle pulse: the operation ended successfully |
| fail_i | input | 1 | One-cycle pulse: the operation ended in failure (wins over done_i) |
| exit_i | input | 1 | Exit command back to array reads |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 2 | Configuration write value |
| rd_i | input | 1 | Read strobe |
| array_data_i | input | DATA_W | Array word at the read address |
| rd_data_o | output | DATA_W | Registered read word |
| rdy_low_o | output | 1 | 1 = pull the open-drain ready/busy line low |
| array_mode_o | output | 1 | 1 when reads return array data |

## Verification
The hardest case to reach is the difference between a pin reset and a power-on reset on the configuration value, because that value never shows directly at the ports. The bench writes configuration 01, pulses the reset pin, then starts a program whose loaded bit 7 is 0. The polling bit only tells the two settings apart through how it is derived. A following power-on reset must flip the outcome. A sweep over configuration, operation kind, loaded bit 7 and outcome also injects exit commands, configuration writes and starts in the middle of each operation. It then confirms through later reads that none of them took effect.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [1:0] {
    ST_ARRAY = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAIL  = 2'd3
  } fsr_state_e;

  // bit positions of the status word
  localparam int POLL_BIT = 7;
  localparam int TOGL_BIT = 6;
  localparam int FAIL_BIT = 5;

  typedef struct packed {
    logic is_erase;
    logic ref_bit;   // bit 7 of the last loaded data
  } op_ctx_t;
endpackage

// File: rtl/fsr_cfg_reg.sv
module fsr_cfg_reg (
  input  logic       clk,
  input  logic       por,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       accept_i,
  output logic [1:0] cfg_o
);
  logic sel_q;

  // only power-on clears the setting
  always_ff @(posedge clk) begin
    if (por)
      sel_q <= 1'b0;
    else if (wr_i && accept_i)
      sel_q <= wdata_i[0];
  end

  assign cfg_o = {1'b0, sel_q};

  // R1: a write outside array mode leaves the setting alone
  assert_cfg_blocked_R1: assert property (@(posedge clk) disable iff (por)
    (wr_i && !accept_i) |=> (cfg_o == $past(cfg_o)));
endmodule

// File: rtl/fsr_seq.sv
module fsr_seq
  import fsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              done_i,
  input  logic              fail_i,
  input  logic              exit_i,
  input  logic              auto_ret_i,
  output fsr_state_e        state_o,
  output op_ctx_t           ctx_o,
  output logic              rdy_low_o
);
  fsr_state_e st_q, st_d;
  op_ctx_t    ctx_q;
  logic       rdy_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ARRAY: if (start_i) st_d = ST_RUN;
      ST_RUN: begin
        if (fail_i)      st_d = ST_FAIL;
        else if (done_i) st_d = auto_ret_i ? ST_ARRAY : ST_DONE;
      end
      ST_DONE:  if (exit_i) st_d = ST_ARRAY;
      ST_FAIL:  if (exit_i) st_d = ST_ARRAY;
      default:  st_d = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_ARRAY;
      ctx_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rdy_q <= (st_d == ST_RUN);
      if (st_q == ST_ARRAY && start_i) begin
        ctx_q.is_erase <= erase_i;
        ctx_q.ref_bit  <= load_i[POLL_BIT];
      end
    end
  end

  assign state_o   = st_q;
  assign ctx_o     = ctx_q;
  assign rdy_low_o = rdy_q;

  // R8: an accepted start pulls the busy line in the next cycle
  assert_busy_pull_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ARRAY && start_i) |=> rdy_low_o);
  // R8: the end of an operation releases it
  assert_busy_free_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && (done_i || fail_i)) |=> !rdy_low_o);
  // R6: failure persists without an exit
  assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FAIL && !exit_i) |=> (st_q == ST_FAIL));
  // R7: success with automatic return lands in array mode
  assert_auto_ret_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && done_i && !fail_i && auto_ret_i) |=> (st_q == ST_ARRAY));
  // R11: a running operation only leaves on done or fail
  assert_run_ignores_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !done_i && !fail_i) |=> (st_q == ST_RUN && $stable(ctx_q)));
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst,
  input  logic rd_i,
  input  logic active_i,
  output logic tgl_o
);
  logic tgl_q;

  always_ff @(posedge clk) begin
    if (rst)
      tgl_q <= 1'b0;
    else if (rd_i && active_i)
      tgl_q <= ~tgl_q;
  end

  assign tgl_o = tgl_q;

  // R4: the flag only moves on a read in a toggling state
  assert_toggle_still_R4: assert property (@(posedge clk) disable iff (rst)
    !(rd_i && active_i) |=> $stable(tgl_o));
endmodule

// File: rtl/fsr_word.sv
module fsr_word
  import fsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  fsr_state_e        state_i,
  input  op_ctx_t           ctx_i,
  input  logic              cfg_hs_i,
  input  logic              tgl_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] stat_w;
  logic              legacy_poll;
  logic              poll;
  logic [DATA_W-1:0] data_q;

  assign legacy_poll = ctx_i.is_erase ? 1'b0 : ~ctx_i.ref_bit;

  always_comb begin
    unique case (state_i)
      ST_RUN:  poll = cfg_hs_i ? 1'b0 : legacy_poll;
      ST_DONE: poll = 1'b1;
      ST_FAIL: poll = cfg_hs_i ? 1'b1 : legacy_poll;
      default: poll = 1'b0;
    endcase
    stat_w           = '0;
    stat_w[POLL_BIT] = poll;
    stat_w[TOGL_BIT] = tgl_i;
    stat_w[FAIL_BIT] = (state_i == ST_FAIL);
  end

  always_ff @(posedge clk) begin
    if (rst)
      data_q <= '0;
    else if (rd_i)
      data_q <= (state_i == ST_ARRAY) ? array_i : stat_w;
  end

  assign data_o = data_q;

  // R9: array reads pass the word through unchanged
  assert_passthru_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_i && state_i == ST_ARRAY) |=> (data_o == $past(array_i)));
  // R5: a status read after failure carries the failure bit
  assert_fail_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_i && state_i == ST_FAIL) |=> data_o[FAIL_BIT]);
  // R5: a read while running shows no failure
  assert_run_nofail_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_i && state_i == ST_RUN) |=> !data_o[FAIL_BIT]);
  // R3: finished success in handshake mode polls high
  assert_done_poll_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_i && state_i == ST_DONE) |=> data_o[POLL_BIT]);
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              done_i,
  input  logic              fail_i,
  input  logic              exit_i,
  input  logic              cfg_wr_i,
  input  logic [1:0]        cfg_data_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rdy_low_o,
  output logic              array_mode_o
);
  localparam int MIN_W = POLL_BIT + 1;

  logic       rst_any;
  logic [1:0] cfg;
  fsr_state_e state;
  op_ctx_t    ctx;
  logic       tgl;
  logic       tgl_active;
  logic       cfg_accept;
  logic       unused_bits;

  assign rst_any     = rst | por;
  assign cfg_accept  = (state == ST_ARRAY) && !rst;
  assign tgl_active  = (state == ST_RUN) || (state == ST_FAIL);
  assign unused_bits = ^{load_data_i, cfg[1]};

  fsr_cfg_reg u_cfg (
    .clk      (clk),
    .por      (por),
    .wr_i     (cfg_wr_i),
    .wdata_i  (cfg_data_i),
    .accept_i (cfg_accept),
    .cfg_o    (cfg)
  );

  fsr_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst_any),
    .start_i    (start_i),
    .erase_i    (erase_i),
    .load_i     (load_data_i),
    .done_i     (done_i),
    .fail_i     (fail_i),
    .exit_i     (exit_i),
    .auto_ret_i (cfg[0] == 1'b0),
    .state_o    (state),
    .ctx_o      (ctx),
    .rdy_low_o  (rdy_low_o)
  );

  fsr_toggle u_tgl (
    .clk      (clk),
    .rst      (rst_any),
    .rd_i     (rd_i),
    .active_i (tgl_active),
    .tgl_o    (tgl)
  );

  fsr_word #(.DATA_W(DATA_W)) u_word (
    .clk      (clk),
    .rst      (rst_any),
    .rd_i     (rd_i),
    .state_i  (state),
    .ctx_i    (ctx),
    .cfg_hs_i (cfg[0]),
    .tgl_i    (tgl),
    .array_i  (array_data_i),
    .data_o   (rd_data_o)
  );

  assign array_mode_o = (state == ST_ARRAY);

  initial assert (DATA_W >= MIN_W) else $error("DATA_W too small for the status bits");

  // R1: a pin reset keeps the configuration value
  assert_cfg_kept_R1: assert property (@(posedge clk) disable iff (por)
    rst |=> (cfg == $past(cfg)));
  // R10: after any reset the block reads the array with the line released
  assert_reset_state_R10: assert property (@(posedge clk)
    rst_any |=> (array_mode_o && !rdy_low_o && rd_data_o == '0));
endmodule

// File: tb/flash_status_unit_test.sv
module flash_status_unit_test;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          por, rst, start_i, erase_i, done_i, fail_i, exit_i, cfg_wr_i, rd_i;
  logic [DW-1:0] load_data_i, array_data_i, rd_data_o;
  logic [1:0]    cfg_data_i;
  logic          rdy_low_o, array_mode_o;

  int  checks = 0;
  int  errors = 0;
  bit  tgl_m  = 1'b0;
  bit  ended  = 1'b0;

  flash_status_unit #(.DATA_W(DW)) uut (
    .clk(clk), .por(por), .rst(rst), .start_i(start_i), .erase_i(erase_i),
    .load_data_i(load_data_i), .done_i(done_i), .fail_i(fail_i), .exit_i(exit_i),
    .cfg_wr_i(cfg_wr_i), .cfg_data_i(cfg_data_i), .rd_i(rd_i),
    .array_data_i(array_data_i), .rd_data_o(rd_data_o), .rdy_low_o(rdy_low_o),
    .array_mode_o(array_mode_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // phase: 0 running, 1 finished success (handshake), 2 failed
  function automatic logic [DW-1:0] stat(bit c1, bit er, bit l7, int ph, bit t);
    logic [DW-1:0] w = '0;
    if (ph == 0)      w[7] = c1 ? 1'b0 : (er ? 1'b0 : ~l7);
    else if (ph == 1) w[7] = 1'b1;
    else              w[7] = c1 ? 1'b1 : (er ? 1'b0 : ~l7);
    w[6] = t;
    w[5] = (ph == 2);
    return w;
  endfunction

  task automatic rd(output logic [DW-1:0] v);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    v = rd_data_o;
  endtask

  task automatic rd_status(input string req, input bit c1, input bit er, input bit l7, input int ph);
    logic [DW-1:0] v;
    rd(v);
    chk(req, v, stat(c1, er, l7, ph, tgl_m));
    if (ph != 1) tgl_m = ~tgl_m;
  endtask

  task automatic rd_array(input string req);
    logic [DW-1:0] v;
    rd(v);
    chk(req, v, array_data_i);
  endtask

  task automatic start(input bit er, input logic [DW-1:0] ld);
    start_i = 1'b1; erase_i = er; load_data_i = ld;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_done(); done_i = 1'b1; @(negedge clk); done_i = 1'b0; endtask
  task automatic pulse_fail(); fail_i = 1'b1; @(negedge clk); fail_i = 1'b0; endtask
  task automatic pulse_exit(); exit_i = 1'b1; @(negedge clk); exit_i = 1'b0; endtask
  task automatic pulse_rst();  rst = 1'b1; @(negedge clk); rst = 1'b0; tgl_m = 1'b0; endtask
  task automatic pulse_por();  por = 1'b1; @(negedge clk); por = 1'b0; tgl_m = 1'b0; endtask
  task automatic wr_cfg(input logic [1:0] d);
    cfg_wr_i = 1'b1; cfg_data_i = d;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    por = 1'b1; rst = 1'b0; start_i = 0; erase_i = 0; done_i = 0; fail_i = 0;
    exit_i = 0; cfg_wr_i = 0; cfg_data_i = 0; rd_i = 0;
    load_data_i = '0; array_data_i = 16'h1234;
    repeat (3) @(negedge clk);
    por = 1'b0;

    // R10: reset state
    chk("R10 rdy", {15'd0, rdy_low_o}, 16'd0);
    chk("R10 mode", {15'd0, array_mode_o}, 16'd1);
    chk("R10 data", rd_data_o, 16'd0);
    rd_array("R9 array passthrough");

    // R1: default setting 00 -> program with bit7=1 polls 0
    start(1'b0, 16'h0080);
    rd_status("R1 default 00", 1'b0, 1'b0, 1'b1, 0);
    pulse_rst();
    chk("R10 pin reset rdy", {15'd0, rdy_low_o}, 16'd0);
    chk("R10 pin reset mode", {15'd0, array_mode_o}, 16'd1);
    chk("R10 pin reset data", rd_data_o, 16'd0);
    rd_array("R10 array after reset");

    // R1: bit 1 of the write dropped, value 01 stored, survives a pin reset
    wr_cfg(2'b11);
    start(1'b0, 16'h0000);
    rd_status("R1 cfg 01 stored", 1'b1, 1'b0, 1'b0, 0);
    pulse_rst();
    start(1'b0, 16'h0000);
    rd_status("R1 cfg kept over pin reset", 1'b1, 1'b0, 1'b0, 0);
    pulse_rst();
    pulse_por();
    start(1'b0, 16'h0000);
    rd_status("R1 cfg cleared by power-on", 1'b0, 1'b0, 1'b0, 0);
    pulse_rst();

    // sweep: setting x kind x loaded bit7 x outcome
    for (int c1 = 0; c1 < 2; c1++)
      for (int er = 0; er < 2; er++)
        for (int l7 = 0; l7 < 2; l7++)
          for (int f = 0; f < 2; f++) begin
            string rq;
            rq = (c1 != 0) ? "R3" : "R2";
            wr_cfg({1'b0, c1[0]});
            array_data_i = 16'h5A00 + 16'(c1 * 8 + er * 4 + l7 * 2 + f);
            start(er[0], {8'h3C, l7[0], 7'h15});
            chk("R8 busy pulled", {15'd0, rdy_low_o}, 16'd1);
            chk("R8 status mode", {15'd0, array_mode_o}, 16'd0);
            rd_status({rq, " R4 R5 R9 run"}, c1[0], er[0], l7[0], 0);
            rd_status({rq, " R4 run"}, c1[0], er[0], l7[0], 0);
            rd_status({rq, " R4 run"}, c1[0], er[0], l7[0], 0);
            // R11: commands during the operation have no effect
            pulse_exit();
            wr_cfg({1'b0, ~c1[0]});
            start(~er[0], {8'h00, ~l7[0], 7'h00});
            chk("R11 still busy", {15'd0, rdy_low_o}, 16'd1);
            rd_status("R11 ignored commands", c1[0], er[0], l7[0], 0);
            if (f != 0) pulse_fail(); else pulse_done();
            chk("R8 busy released", {15'd0, rdy_low_o}, 16'd0);
            if (f != 0) begin
              rd_status({rq, " R5 R4 failed"}, c1[0], er[0], l7[0], 2);
              rd_status({rq, " R5 R4 failed"}, c1[0], er[0], l7[0], 2);
              chk("R6 held in status", {15'd0, array_mode_o}, 16'd0);
              pulse_exit();
              chk("R6 exit to array", {15'd0, array_mode_o}, 16'd1);
              rd_array("R6 array after exit");
            end else if (c1 != 0) begin
              rd_status("R3 R4 finished", 1'b1, er[0], l7[0], 1);
              rd_status("R3 R4 finished", 1'b1, er[0], l7[0], 1);
              chk("R7 waits for exit", {15'd0, array_mode_o}, 16'd0);
              pulse_exit();
              rd_array("R7 array after exit");
            end else begin
              chk("R7 auto return", {15'd0, array_mode_o}, 16'd1);
              rd_array("R7 array after success");
            end
          end

    summary();
  end
endmodule